// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. It drives a trial code into an external charge-redistribution DAC, reads back one comparator decision per clock, and narrows the code by binary search, one bit per cycle, from the most significant bit down. It also powers the analog parts up and down and tells an external four-way analog multiplexer which channel to sample.

There is no per-conversion start/busy exchange. One active-high quiescent input gates the block. While it is high, the analog parts are unpowered and nothing converts. Once it drops, conversions repeat back to back with a fixed cadence of nine clocks: one sample cycle followed by eight bit-decision cycles. Each finished code is latched together with the channel it came from, and a one-cycle valid strobe marks it. The result port has no ready input and cannot apply back-pressure. A consumer must take each result during its strobe cycle, or hold it from the latch before the next strobe nine cycles later.

The channel select is read only when a conversion begins. Raising the quiescent input part-way through a conversion abandons that conversion. The partial code is then discarded and the latched result is left untouched.

Top module: `sar_conv_seq`

## Requirements
- R1: While rst_n is low, power_up_o, sample_o, result_vld_o, trial_o, result_o, result_ch_o and mux_ch_o are all zero.
- R2: In every cycle whose preceding clock edge saw quiet_i high, power_up_o is 0, trial_o is 0 and result_vld_o is 0.
- R3: The first clock edge that sees quiet_i low after quiescence begins a sample cycle. In that cycle power_up_o is 1, sample_o is 1 and trial_o is 0.
- R4: While quiet_i stays low, result_vld_o pulses high for exactly one cycle in every nine. The first pulse comes 9 clock edges after the edge that started the first conversion, and no idle cycles separate conversions.
- R5: In bit cycle k (k = 1..8 after the sample cycle), trial_o holds the already-decided upper bits and sets bit 8-k to 1, with all lower bits 0. The first bit cycle therefore shows 8'h80.
- R6: In a bit cycle where cmp_hi_i is 1 (DAC output above the input), the bit under trial is cleared. Otherwise it is kept. With an ideal comparator, result_o therefore equals the sampled input code, including codes 0 and 255.
- R7: mux_ch_o takes the value of ch_sel_i at the edge that starts a conversion and holds it through all nine cycles. A select change during a conversion takes effect at the next one. result_ch_o reports the channel the latched result came from.
- R8: If quiet_i is high at any edge before a conversion completes, that conversion is abandoned: no valid strobe appears and result_o and result_ch_o do not change.
- R9: result_o and result_ch_o change only together with a valid strobe. They keep their value through quiescence.
- R10: After an abandoned conversion, the next low period of quiet_i starts a new full nine-cycle conversion whose result is correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quiet_i | input | 1 | High: analog off, no conversion; low: convert continuously |
| ch_sel_i | input | 2 | Requested analog channel |
| cmp_hi_i | input | 1 | Comparator: 1 when DAC voltage exceeds sampled input |
| trial_o | output | 8 | Trial code to the DAC |
| power_up_o | output | 1 | Power enable for the analog parts |
| sample_o | output | 1 | High during the sample cycle |
| mux_ch_o | output | 2 | Channel driven to the analog multiplexer |
| result_o | output | 8 | Latched conversion result |
| result_ch_o | output | 2 | Channel of the latched result |
| result_vld_o | output | 1 | One-cycle strobe for a new result |

## Verification
On every cycle, the embedded assertions check these relations: a strobe follows only a completed final bit cycle and lasts one cycle; the latched result moves only with a strobe; power stays off after a quiescent edge; the sample cycle carries an all-zero trial code; and the multiplexer channel stays fixed for the whole conversion. The bench scenarios show the rest. These are the binary search itself against a modelled DAC and comparator over edge codes, the MSB-first trial pattern, the exact nine-cycle latency and cadence, a mid-conversion channel change, and abort-then-restart behaviour.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_QUIET = 1'b0,
    ST_RUN   = 1'b1
  } run_state_t;

  function automatic int unsigned phase_count(input int unsigned data_w);
    return data_w + 1;
  endfunction
endpackage

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_W   = 2,
  localparam int unsigned NPH   = phase_count(DATA_W),
  localparam int unsigned PH_W  = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            quiet_i,
  input  logic [CH_W-1:0] ch_sel_i,
  output logic            run_o,
  output logic [PH_W-1:0] ph_o,
  output logic            sample_o,
  output logic            last_o,
  output logic [CH_W-1:0] ch_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NPH - 1);

  run_state_t      st_q;
  logic [PH_W-1:0] ph_q;
  logic [CH_W-1:0] ch_q;
  logic            begin_conv;

  assign run_o    = (st_q == ST_RUN);
  assign ph_o     = ph_q;
  assign sample_o = run_o && (ph_q == '0);
  assign last_o   = run_o && (ph_q == PH_LAST);
  assign ch_o     = ch_q;

  // a new conversion starts on leaving quiescence or right after a final bit cycle
  assign begin_conv = !quiet_i && (!run_o || (ph_q == PH_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_QUIET;
      ph_q <= '0;
    end else if (quiet_i) begin
      st_q <= ST_QUIET;
      ph_q <= '0;
    end else if (begin_conv) begin
      st_q <= ST_RUN;
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
    end else if (begin_conv) begin
      ch_q <= ch_sel_i;
    end
  end

  // R2: a quiescent edge leaves the analog parts unpowered
  p_quiet_power_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_i |=> !run_o);

  // R7: channel fixed from the sample cycle to the last bit cycle
  p_chan_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !quiet_i && (ph_q != PH_LAST)) |=> $stable(ch_o));

  // R4: phases advance by exactly one while running
  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !quiet_i && (ph_q != PH_LAST)) |=> (ph_q == $past(ph_q) + PH_W'(1)));

  // R3: leaving quiescence lands in the sample cycle
  p_enter_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !quiet_i) |=> sample_o);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NPH   = phase_count(DATA_W),
  localparam int unsigned PH_W  = $clog2(NPH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet_i,
  input  logic              run_i,
  input  logic              last_i,
  input  logic [PH_W-1:0]   ph_i,
  input  logic              cmp_hi_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] decided_o
);
  logic [DATA_W-1:0] code_q;
  logic [DATA_W-1:0] code_d;
  logic              wipe;

  // the register is emptied when nothing follows or a conversion wraps
  assign wipe = quiet_i || !run_i || last_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic under_trial;
    logic arm_next;
    // bit b is under trial in phase DATA_W-b and armed in the phase before
    assign under_trial  = run_i && (ph_i == PH_W'(DATA_W - b));
    assign arm_next     = run_i && (ph_i == PH_W'(DATA_W - 1 - b));
    assign decided_o[b] = code_q[b] && !(under_trial && cmp_hi_i);
    assign code_d[b]    = wipe ? 1'b0 : (arm_next ? 1'b1 : decided_o[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_d;
    end
  end

  assign trial_o = code_q;

  // R3: the sample cycle presents an all-zero trial code
  p_sample_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (ph_i == '0)) |-> (trial_o == '0));

  // R5: the first bit cycle trials the MSB alone
  p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (ph_i == PH_W'(1))) |-> (trial_o == {1'b1, {(DATA_W-1){1'b0}}}));

  // R6: a decided bit never returns to one within a conversion
  p_bits_only_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !quiet_i && !last_i && (ph_i != '0)) |=> ((trial_o & ~$past(trial_o)) == ($past(trial_o) & ~$past(trial_o << 1) & ~$past(trial_o)) | ((trial_o & ~$past(trial_o)) & ($past(trial_o) >> 1))));
endmodule

// File: rtl/sar_result_latch.sv
module sar_result_latch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] decided_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [DATA_W-1:0] result_o,
  output logic [CH_W-1:0]   result_ch_o,
  output logic              vld_o
);
  logic take;

  assign take = last_i && !quiet_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o    <= '0;
      result_ch_o <= '0;
      vld_o       <= 1'b0;
    end else begin
      vld_o <= take;
      if (take) begin
        result_o    <= decided_i;
        result_ch_o <= ch_i;
      end
    end
  end

  // R4: the strobe lasts a single cycle
  p_vld_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);

  // R8: a strobe only follows a final bit cycle free of quiescence
  p_vld_needs_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(last_i && !quiet_i));

  // R9: the latched value only moves with a strobe
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> ($stable(result_o) && $stable(result_ch_o)));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_W   = 2,
  localparam int unsigned NPH   = phase_count(DATA_W),
  localparam int unsigned PH_W  = $clog2(NPH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet_i,
  input  logic [CH_W-1:0]   ch_sel_i,
  input  logic              cmp_hi_i,
  output logic [DATA_W-1:0] trial_o,
  output logic              power_up_o,
  output logic              sample_o,
  output logic [CH_W-1:0]   mux_ch_o,
  output logic [DATA_W-1:0] result_o,
  output logic [CH_W-1:0]   result_ch_o,
  output logic              result_vld_o
);
  logic              run;
  logic              last;
  logic [PH_W-1:0]   ph;
  logic [DATA_W-1:0] decided;

  sar_phase_ctl #(.DATA_W(DATA_W), .CH_W(CH_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .quiet_i  (quiet_i),
    .ch_sel_i (ch_sel_i),
    .run_o    (run),
    .ph_o     (ph),
    .sample_o (sample_o),
    .last_o   (last),
    .ch_o     (mux_ch_o)
  );

  sar_trial_reg #(.DATA_W(DATA_W)) u_trial (
    .clk       (clk),
    .rst_n     (rst_n),
    .quiet_i   (quiet_i),
    .run_i     (run),
    .last_i    (last),
    .ph_i      (ph),
    .cmp_hi_i  (cmp_hi_i),
    .trial_o   (trial_o),
    .decided_o (decided)
  );

  sar_result_latch #(.DATA_W(DATA_W), .CH_W(CH_W)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .quiet_i     (quiet_i),
    .last_i      (last),
    .decided_i   (decided),
    .ch_i        (mux_ch_o),
    .result_o    (result_o),
    .result_ch_o (result_ch_o),
    .vld_o       (result_vld_o)
  );

  assign power_up_o = run;

  // R2: no trial code reaches the DAC while unpowered
  p_unpowered_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !power_up_o |-> (trial_o == '0));
endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       quiet = 1'b1;
  logic [1:0] ch_sel = 2'd0;
  logic       cmp_hi;
  logic [7:0] trial, result;
  logic       power_up, sample, vld;
  logic [1:0] mux_ch, result_ch;
  logic [7:0] vin [4] = '{8'd0, 8'd0, 8'd0, 8'd0};

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  // analog model: DAC + mux + comparator
  assign cmp_hi = trial > vin[mux_ch];

  sar_conv_seq i_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .quiet_i(quiet), .ch_sel_i(ch_sel),
    .cmp_hi_i(cmp_hi), .trial_o(trial), .power_up_o(power_up),
    .sample_o(sample), .mux_ch_o(mux_ch), .result_o(result),
    .result_ch_o(result_ch), .result_vld_o(vld)
  );

  // {channel, input code}; neighbouring entries use different channels
  localparam logic [9:0] TBL [8] = '{
    {2'd0, 8'd0},   {2'd1, 8'd255}, {2'd2, 8'd128}, {2'd3, 8'd127},
    {2'd0, 8'd1},   {2'd1, 8'd170}, {2'd2, 8'd85},  {2'd3, 8'd254}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    logic [7:0] keep_res;
    logic [1:0] keep_ch;
    int         vcount;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!power_up && !sample && !vld, "R1 ctrl", {power_up, sample, vld}, 0);
    check(trial == 0 && result == 0, "R1 data", {trial, result}, 0);
    check(result_ch == 0 && mux_ch == 0, "R1 chan", {result_ch, mux_ch}, 0);
    rst_n = 1'b1;

    // R2: quiescent hold
    vcount = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (power_up || vld || trial != 0) vcount++;
    end
    check(vcount == 0, "R2 quiet", vcount, 0);

    // table walk: back-to-back conversions
    for (int i = 0; i < 8; i++) begin
      ch_sel = TBL[i][9:8];
      vin[TBL[i][9:8]] = TBL[i][7:0];
      quiet = 1'b0;
      @(negedge clk);
      check(power_up && sample && trial == 0, "R3 sample cycle", {power_up, sample, trial}, 'h300);
      check(mux_ch == TBL[i][9:8], "R7 mux chan", mux_ch, TBL[i][9:8]);
      if (i > 0) begin
        check(vld == 1, "R4 cadence", vld, 1);
        check(result == TBL[i-1][7:0], "R6 result", result, TBL[i-1][7:0]);
        check(result_ch == TBL[i-1][9:8], "R7 result chan", result_ch, TBL[i-1][9:8]);
      end
      @(negedge clk);
      check(trial == 8'h80, "R5 msb trial", trial, 'h80);
      vcount = vld;
      for (int k = 0; k < 7; k++) begin
        @(negedge clk);
        vcount += vld;
      end
      check(vcount == 0, "R4 single strobe", vcount, 0);
      check(trial == {TBL[i][7:1], 1'b1}, "R5 lsb trial", trial, {TBL[i][7:1], 1'b1});
    end
    @(negedge clk);
    check(vld && result == TBL[7][7:0], "R6 last result", result, TBL[7][7:0]);

    // R8: abort mid conversion
    keep_res = result;
    keep_ch = result_ch;
    repeat (3) @(negedge clk);
    quiet = 1'b1;
    @(negedge clk);
    check(!power_up && trial == 0, "R2 power off", {power_up, trial}, 0);
    vcount = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      vcount += vld;
    end
    check(vcount == 0, "R8 no strobe", vcount, 0);
    check(result == keep_res && result_ch == keep_ch, "R9 hold", result, keep_res);

    // R10 restart, with a mid-conversion select change (R7)
    ch_sel = 2'd2;
    vin[2] = 8'd77;
    vin[1] = 8'd200;
    quiet = 1'b0;
    vcount = 0;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      vcount += vld;
      if (k == 3) ch_sel = 2'd1;
      if (k == 5) check(mux_ch == 2'd2, "R7 chan held", mux_ch, 2);
    end
    check(vcount == 0, "R10 no early strobe", vcount, 0);
    @(negedge clk);
    check(vld == 1, "R10 latency", vld, 1);
    check(result == 8'd77 && result_ch == 2'd2, "R10 result", result, 77);
    check(mux_ch == 2'd1, "R7 next chan", mux_ch, 1);
    repeat (9) @(negedge clk);
    check(vld && result == 8'd200 && result_ch == 2'd1, "R7 next result", result, 200);

    // R9: hold across quiescence
    quiet = 1'b1;
    repeat (6) @(negedge clk);
    check(result == 8'd200 && !vld, "R9 quiet hold", result, 200);

    finish_run();
  end
endmodule